// File: doc/BRIEF.md
# Multi-Core Event Signalling Hub

This block carries wake-up events between the cores of a cluster that park themselves in a wait-for-event state. Each core has its own one-bit event flag. When any core strobes its send-event line, every core's flag is set. A strobe on the external event input has the same effect, so an agent outside the cluster can wake the cores. It uses this to say that a shared resource, such as a semaphore, has been released.

A core uses its flag in one of three ways:
- It clears the flag with an explicit consume strobe.
- It executes wait-for-event while the flag is already set. The flag is cleared and the core keeps running.
- It executes wait-for-event while the flag is clear. The core goes to sleep until an event arrives. On wake-up the flag is consumed.

Separately, every send-event issued inside the cluster raises the external event output for a fixed three-cycle window. Outside agents can watch that output. Clock gating and instruction retirement are handled elsewhere; this block only tracks the per-core flag and sleep state.

Top module: `evt_hub`

## Requirements
- R1: A send-event strobe from any one or more cores at a rising clock edge sets the event flag of every core, visible on `evt_pend_o` in the following cycle.
- R2: `ext_evt_i` sampled high at a rising edge sets the event flag of every core in the following cycle, exactly like a send-event, but it does not raise `ext_evt_o`.
- R3: After a rising edge at which any `sev_i` bit is high, `ext_evt_o` is high for exactly 3 consecutive cycles (parameter `PULSE_LEN`) and then low, unless another send-event arrives.
- R4: A send-event arriving while `ext_evt_o` is high restarts the window, so the output stays high for a full 3 cycles counted from the new event.
- R5: A sleeping core whose flag is set shows `wake_o` high for that cycle. In the next cycle it is awake (`sleep_o` low), and its flag has been consumed unless a new set arrived at the same edge.
- R6: A wait-for-event strobe on an awake core whose flag is set clears the flag and leaves the core awake.
- R7: A wait-for-event strobe on an awake core whose flag is clear puts the core to sleep in the next cycle. A wait-for-event strobe on a core that is already asleep has no effect.
- R8: A consume strobe clears the core's flag. A consume or wait-for-event clear that coincides with a new set leaves the flag set.
- R9: During and right after reset (`rst_n` low, asynchronous), all flags, sleep states, wake flags and `ext_evt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sev_i | input | NUM_CORES | Per-core send-event strobe |
| ext_evt_i | input | 1 | External event input, sampled on rising edges |
| clr_i | input | NUM_CORES | Per-core consume strobe for the event flag |
| wfe_i | input | NUM_CORES | Per-core wait-for-event strobe |
| evt_pend_o | output | NUM_CORES | Per-core event flag |
| sleep_o | output | NUM_CORES | Per-core wait-for-event sleep state |
| wake_o | output | NUM_CORES | Per-core wake indication (asleep with flag set) |
| ext_evt_o | output | 1 | External event output, three-cycle window per send-event |

## Verification
The bench goes after the following corner cases:
- **Pulse restart.** A second send-event lands two cycles into the window. A design that ignores it drops `ext_evt_o` a cycle early. A design that adds the windows together keeps it high too long.
- **Set and clear in the same cycle.** Consume and set coincide. A design with clear priority would lose a wake-up and leave a core sleeping forever.
- **Wait-for-event with the flag already set.** A design that sleeps anyway would deadlock the core.
- **External input.** A design that feeds the external input into the output window would echo events back to the outside agent.

Long random runs, with sleeping cores mixed among the strobes, cover wake-up and consumption in every ordering.

// File: rtl/evt_hub_pkg.sv
package evt_hub_pkg;

  typedef enum logic {
    SLOT_RUN  = 1'b0,
    SLOT_WAIT = 1'b1
  } slot_state_e;

  // Next value of a one-bit flag: a set always wins over a clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/evt_bcast.sv
module evt_bcast #(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0] sev_i,
  input  logic                 ext_evt_i,
  output logic                 sev_any_o,
  output logic                 bcast_o
);

  always_comb begin
    sev_any_o = |sev_i;
    bcast_o   = sev_any_o | ext_evt_i;
  end

endmodule

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen #(
  parameter int PULSE_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  // A start reloads the full length; otherwise count down to zero.
  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] cur, input logic start);
    if (start)
      return LOAD_VAL;
    else if (cur != '0)
      return cur - 1'b1;
    else
      return '0;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= count_next(cnt_q, start_i);
  end

  assign active_o = (cnt_q != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_o) else $error("pulse not started"); // R3
  AST_PULSE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && cnt_q == CNT_W'(1)) |=> !active_o) else $error("pulse overran"); // R3
  AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && active_o) |=> (cnt_q == LOAD_VAL)) else $error("pulse not restarted"); // R4
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL) else $error("pulse counter out of range"); // R3

endmodule

// File: rtl/evt_core_slot.sv
module evt_core_slot
  import evt_hub_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bcast_i,
  input  logic clr_i,
  input  logic wfe_i,
  output logic pend_o,
  output logic sleep_o,
  output logic wake_o
);

  slot_state_e state_q, state_d;
  logic        pend_q, pend_d;
  logic        wfe_hit;    // wait-for-event finds the flag set
  logic        wfe_enter;  // wait-for-event finds the flag clear
  logic        wake_now;   // sleeping with flag set
  logic        consume;

  always_comb begin
    wfe_hit   = wfe_i & pend_q & (state_q == SLOT_RUN);
    wfe_enter = wfe_i & ~pend_q & (state_q == SLOT_RUN);
    wake_now  = (state_q == SLOT_WAIT) & pend_q;
    consume   = clr_i | wfe_hit | wake_now;
    pend_d    = flag_next(pend_q, bcast_i, consume);
    state_d   = state_q;
    if (wfe_enter)     state_d = SLOT_WAIT;
    else if (wake_now) state_d = SLOT_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      state_q <= SLOT_RUN;
    end else begin
      pend_q  <= pend_d;
      state_q <= state_d;
    end
  end

  assign pend_o  = pend_q;
  assign sleep_o = (state_q == SLOT_WAIT);
  assign wake_o  = wake_now;

  AST_SET_ON_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_i |=> pend_o) else $error("broadcast lost"); // R1
  AST_WAKE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && pend_o) |=> !sleep_o) else $error("core stayed asleep"); // R5
  AST_WFE_SET_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wfe_i && pend_o && !sleep_o) |=> !sleep_o) else $error("slept with flag set"); // R6
  AST_WFE_CLEAR_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wfe_i && !pend_o && !sleep_o) |=> sleep_o) else $error("did not sleep"); // R7
  AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !bcast_i) |=> !pend_o) else $error("consume ignored"); // R8

endmodule

// File: rtl/evt_hub.sv
module evt_hub #(
  parameter int NUM_CORES = 4,
  parameter int PULSE_LEN = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] sev_i,
  input  logic                 ext_evt_i,
  input  logic [NUM_CORES-1:0] clr_i,
  input  logic [NUM_CORES-1:0] wfe_i,
  output logic [NUM_CORES-1:0] evt_pend_o,
  output logic [NUM_CORES-1:0] sleep_o,
  output logic [NUM_CORES-1:0] wake_o,
  output logic                 ext_evt_o
);

  logic sev_any;
  logic bcast;

  evt_bcast #(.NUM_CORES(NUM_CORES)) u_bcast (
    .sev_i     (sev_i),
    .ext_evt_i (ext_evt_i),
    .sev_any_o (sev_any),
    .bcast_o   (bcast)
  );

  evt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (sev_any),
    .active_o (ext_evt_o)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
    evt_core_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .bcast_i (bcast),
      .clr_i   (clr_i[c]),
      .wfe_i   (wfe_i[c]),
      .pend_o  (evt_pend_o[c]),
      .sleep_o (sleep_o[c]),
      .wake_o  (wake_o[c])
    );
  end

  AST_EXT_NO_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_evt_i && !sev_any && !ext_evt_o) |=> !ext_evt_o) else $error("external input echoed"); // R2
  AST_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt_i |=> (&evt_pend_o)) else $error("external event not broadcast"); // R2

endmodule

// File: tb/evt_hub_bench.sv
`timescale 1ns/100ps
module evt_hub_bench;

  localparam int N   = 4;
  localparam int LEN = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] sev = '0, clr = '0, wfe = '0;
  logic         ext = 1'b0;
  logic [N-1:0] pend, slp, wake;
  logic         ext_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [N-1:0] m_pend = '0, m_slp = '0;
  int           m_cnt = 0;

  always #2.5 clk = ~clk;

  evt_hub #(.NUM_CORES(N), .PULSE_LEN(LEN)) u_evt_hub (
    .clk(clk), .rst_n(rst_n), .sev_i(sev), .ext_evt_i(ext), .clr_i(clr),
    .wfe_i(wfe), .evt_pend_o(pend), .sleep_o(slp), .wake_o(wake), .ext_evt_o(ext_o)
  );

  // reference: flag per core, set dominates every clearing cause
  function automatic logic [N-1:0] ref_pend(input logic [N-1:0] p, input logic [N-1:0] s,
      input logic set_all, input logic [N-1:0] c, input logic [N-1:0] w);
    logic [N-1:0] used;
    used = c | (w & p & ~s) | (s & p);
    return set_all ? {N{1'b1}} : (p & ~used);
  endfunction

  function automatic logic [N-1:0] ref_sleep(input logic [N-1:0] p, input logic [N-1:0] s,
      input logic [N-1:0] w);
    return (s & ~p) | (~s & w & ~p);
  endfunction

  function automatic int ref_cnt(input int cur, input logic fire);
    if (fire) return LEN;
    return (cur > 0) ? cur - 1 : 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 evt_pend_o", 32'(pend), 32'(m_pend));
    chk("R7 sleep_o",    32'(slp),  32'(m_slp));
    chk("R5 wake_o",     32'(wake), 32'(m_slp & m_pend));
    chk("R3 ext_evt_o",  32'(ext_o), 32'(m_cnt != 0));
  endtask

  task automatic step(input logic [N-1:0] s, input logic e, input logic [N-1:0] c,
      input logic [N-1:0] w);
    logic [N-1:0] np, ns;
    int nc;
    sev = s; ext = e; clr = c; wfe = w;
    np = ref_pend(m_pend, m_slp, (|s) | e, c, w);
    ns = ref_sleep(m_pend, m_slp, w);
    nc = ref_cnt(m_cnt, |s);
    @(posedge clk);
    m_pend = np; m_slp = ns; m_cnt = nc;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 pend", 32'(pend), 0);
    chk("R9 sleep", 32'(slp), 0);
    chk("R9 wake", 32'(wake), 0);
    chk("R9 ext", 32'(ext_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: external input sets every flag, output window stays low
    step('0, 1'b1, '0, '0);
    chk("R2 pend", 32'(pend), 32'hF);
    chk("R2 ext", 32'(ext_o), 0);
    // R6: wait-for-event with flag set consumes it, core stays awake
    step('0, 1'b0, '0, 4'b0001);
    chk("R6 pend0", 32'(pend[0]), 0);
    chk("R6 sleep0", 32'(slp[0]), 0);
    // R7: wait-for-event with flag clear sleeps
    step('0, 1'b0, '0, 4'b0001);
    chk("R7 sleep0", 32'(slp[0]), 1);
    step('0, 1'b0, '0, 4'b0001);  // ignored while asleep
    chk("R7 sleep0 ignored", 32'(slp[0]), 1);
    // R1/R5: send-event from core 2 wakes core 0
    step(4'b0100, 1'b0, '0, '0);
    chk("R1 pend", 32'(pend), 32'hF);
    chk("R5 wake0", 32'(wake[0]), 1);
    chk("R3 ext on", 32'(ext_o), 1);
    step('0, 1'b0, '0, '0);
    chk("R5 awake0", 32'(slp[0]), 0);
    chk("R5 consumed0", 32'(pend[0]), 0);
    // R4: restart during window
    step(4'b0010, 1'b0, '0, '0);
    step('0, 1'b0, '0, '0);
    step('0, 1'b0, '0, '0);
    chk("R4 still high", 32'(ext_o), 1);
    step('0, 1'b0, '0, '0);
    chk("R3 low after window", 32'(ext_o), 0);
    // R8: consume vs set in the same cycle, then plain consume
    step(4'b0001, 1'b0, 4'b0100, '0);
    chk("R8 set wins", 32'(pend[2]), 1);
    step('0, 1'b0, 4'b0100, '0);
    chk("R8 consume", 32'(pend[2]), 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] s, c, w;
      logic e;
      for (int k = 0; k < N; k++) begin
        s[k] = ($urandom_range(0, 15) == 0);
        c[k] = ($urandom_range(0, 7) == 0);
        w[k] = ($urandom_range(0, 4) == 0);
      end
      e = ($urandom_range(0, 19) == 0);
      step(s, e, c, w);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule